// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between an on-chip master and an external asynchronous static RAM that stores one byte per address. The master raises a request with an address, a write flag and write data, keeps it steady, and waits for a one-cycle acknowledge. A read returns its byte on a registered data output in the acknowledge cycle. On the memory side the controller drives the address, two chip enables (one active low, one active high), an active-low write strobe, an active-low output enable, and a byte-wide data bus split into out, in and drive-enable signals.

The memory has no clock, so each phase is held for a whole number of controller cycles. These counts are derived from the memory's minimum times in picoseconds and the clock period, all of them parameters. The output enable and the controller's data drivers are never on together. A gap of idle cycles follows every read before the controller drives the bus again, so that the memory has released it. A standby input, taken while the controller is idle, deselects the memory through both enables until the input drops.

Top module: `async_sram_ctrl`

## Requirements
- R1: During reset the memory is selected (mem_ce_n = 0, mem_ce = 1), mem_we_n = 1, mem_oe_n = 1, mem_dq_oe = 0 and req_ack = 0.
- R2: mem_we_n or mem_oe_n is low only while the memory is selected, that is mem_ce_n = 0 and mem_ce = 1.
- R3: A read holds mem_oe_n low, with mem_we_n high and the address steady, for exactly RD_CYC = max(ceil(T_RC/Tclk), ceil(T_OE/Tclk)) cycles. rsp_rdata is the byte on mem_dq_in in the last of those cycles.
- R4: A write holds mem_we_n low for exactly STRB_CYC = max(ceil(T_WP/Tclk), ceil(T_DS/Tclk)) cycles with the address steady. mem_dq_oe is high from the cycle before the strobe falls through the cycle after it rises.
- R5: mem_dq_oe is never high while mem_oe_n is low.
- R6: Between the last cycle with mem_oe_n low and the next cycle with mem_dq_oe high lie at least TURN_CYC = max(MIN_TURN, ceil(T_OE_HZ/Tclk)) cycles with mem_oe_n high.
- R7: req_ack is a single-cycle pulse. It comes in the cycle after mem_oe_n rises at the end of a read, and in the cycle after mem_we_n rises at the end of a write.
- R8: When standby_req is high while the controller is idle, the next cycle shows mem_ce_n = 1 and mem_ce = 0. This lasts until standby_req drops. Meanwhile no request is started or acknowledged, and standby wins over a request that arrives in the same cycle.
- R9: mem_we_n and mem_oe_n are never low together, and each request receives exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request pending; held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Byte to write |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Byte returned by the last read |
| standby_req | input | 1 | Request to deselect the memory |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_in | input | DATA_W | Data returned by the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The bound checker watches every cycle for the pin-level rules. It checks that the data drivers and the output enable never overlap and that the two strobes never overlap. It checks that strobes occur only with the memory selected and that the data is driven through the whole write strobe. Counter-based properties give the exact length of each read phase and the length of the turnaround gap. Whether the right byte lands at the right address, and whether a read returns it, can only be shown by the bench's scenarios. The bench sweeps every address of a small memory model, then mixes reads and writes back to back. It also shows standby holding off pending and simultaneous requests.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the asynchronous static RAM controller.
// Assumes all times are integer picoseconds and the clock period is nonzero.
package sram_ctrl_pkg;

    // Sequencer states; encoding is local to the block.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STBY  = 3'd1,
        ST_RD    = 3'd2,
        ST_WTURN = 3'd3,
        ST_WSET  = 3'd4,
        ST_WSTRB = 3'd5,
        ST_DONE  = 3'd6
    } seq_state_t;

    // Whole cycles needed to cover a minimum time.
    function automatic int cyc_ceil(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Down-counter that times one phase of a memory access.
// Loading value N-1 makes expired high in the N-th cycle of the phase.
// Assumes the sequencer only looks at expired inside a timed phase.
module sram_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_bus_guard.sv
`timescale 1ns/1ps
// Tracks how long the memory's output enable has been released and
// reports when the controller may start driving the shared data bus.
// Assumes oe_n is the registered pin value seen by the memory.
module sram_bus_guard #(
    parameter int CNT_W    = 8,
    parameter int TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic bus_free
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(TURN_CYC - 1);

    logic [CNT_W-1:0] gap_q;

    // Count released cycles since the last output-enable cycle, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= SAT;
        end else if (!oe_n) begin
            gap_q <= '0;
        end else if (gap_q != SAT) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // The current cycle is also released, so one less is enough here.
    assign bus_free = oe_n && (gap_q == SAT);
endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
// Access sequencer: accepts a request or a standby request while idle
// and steps through the read, turnaround, write setup, strobe and done
// phases. Provides the next state so the pin stage can register outputs.
// Assumes req_valid and its fields stay steady until the acknowledge.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int RD_CYC   = 4,
    parameter int STRB_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             standby_req,
    input  logic             bus_free,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             rd_capture,
    output seq_state_t       nxt_state,
    output logic             nxt_wr
);
    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] STRB_LD = CNT_W'(STRB_CYC - 1);

    seq_state_t state_q;
    logic       wr_q;

    // Next-state and phase-timer load decisions.
    always_comb begin
        nxt_state = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (standby_req) begin
                    nxt_state = ST_STBY;
                end else if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        nxt_state = bus_free ? ST_WSET : ST_WTURN;
                    end else begin
                        nxt_state = ST_RD;
                        tmr_load  = 1'b1;
                        tmr_val   = RD_LD;
                    end
                end
            end
            ST_STBY:  if (!standby_req) nxt_state = ST_IDLE;
            ST_RD:    if (tmr_expired) nxt_state = ST_DONE;
            ST_WTURN: if (bus_free) nxt_state = ST_WSET;
            ST_WSET: begin
                nxt_state = ST_WSTRB;
                tmr_load  = 1'b1;
                tmr_val   = STRB_LD;
            end
            ST_WSTRB: if (tmr_expired) nxt_state = ST_DONE;
            ST_DONE:  nxt_state = ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    // Read data is taken in the last cycle of the read phase.
    assign rd_capture = (state_q == ST_RD) && tmr_expired;
    assign nxt_wr     = accept ? req_write : wr_q;

    // State register and direction of the access in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= nxt_state;
            wr_q    <= nxt_wr;
        end
    end
endmodule

// File: rtl/sram_pin_reg.sv
`timescale 1ns/1ps
// Registered memory-side pins and master-side response. Every strobe is
// a flop output decoded from the sequencer's next state, so the memory
// never sees combinational glitches on its enables or strobes.
// Assumes mem_dq_in is valid in the last cycle of a read phase.
module sram_pin_reg
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        nxt_state,
    input  logic              nxt_wr,
    input  logic              accept,
    input  logic              rd_capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic stby_n, drive_n;

    assign stby_n  = (nxt_state != ST_STBY);
    assign drive_n = (nxt_state == ST_WSET) || (nxt_state == ST_WSTRB) ||
                     ((nxt_state == ST_DONE) && nxt_wr);

    // Enable and strobe pins follow the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b0;
            mem_ce    <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            req_ack   <= 1'b0;
        end else begin
            mem_ce_n  <= !stby_n;
            mem_ce    <= stby_n;
            mem_we_n  <= (nxt_state != ST_WSTRB);
            mem_oe_n  <= (nxt_state != ST_RD);
            mem_dq_oe <= drive_n;
            req_ack   <= (nxt_state == ST_DONE);
        end
    end

    // Address and write data are latched when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Read byte captured at the end of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (rd_capture) begin
            rsp_rdata <= mem_dq_in;
        end
    end
endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
// Top level of the asynchronous static RAM controller. Derives phase
// lengths from the memory's minimum times and the clock period, and
// joins the sequencer, phase timer, bus guard and pin register stage.
// Assumes one outstanding request at a time from the master.
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CNT_W         = 8,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int T_RC_PS       = 35000,
    parameter int T_OE_PS       = 15000,
    parameter int T_WP_PS       = 20000,
    parameter int T_DS_PS       = 15000,
    parameter int T_OE_HZ_PS    = 12000,
    parameter int MIN_TURN      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              standby_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int RD_CYC   = imax(cyc_ceil(T_RC_PS, CLK_PERIOD_PS),
                                   cyc_ceil(T_OE_PS, CLK_PERIOD_PS));
    localparam int STRB_CYC = imax(cyc_ceil(T_WP_PS, CLK_PERIOD_PS),
                                   cyc_ceil(T_DS_PS, CLK_PERIOD_PS));
    localparam int TURN_CYC = imax(MIN_TURN,
                                   cyc_ceil(T_OE_HZ_PS, CLK_PERIOD_PS));

    logic             tmr_load, tmr_expired, bus_free;
    logic             accept, rd_capture, nxt_wr;
    logic [CNT_W-1:0] tmr_val;
    seq_state_t       nxt_state;

    sram_seq #(
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .STRB_CYC (STRB_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .standby_req (standby_req),
        .bus_free    (bus_free),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .rd_capture  (rd_capture),
        .nxt_state   (nxt_state),
        .nxt_wr      (nxt_wr)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_bus_guard #(
        .CNT_W    (CNT_W),
        .TURN_CYC (TURN_CYC)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (mem_oe_n),
        .bus_free (bus_free)
    );

    sram_pin_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_state  (nxt_state),
        .nxt_wr     (nxt_wr),
        .accept     (accept),
        .rd_capture (rd_capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_ce     (mem_ce),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .req_ack    (req_ack),
        .rsp_rdata  (rsp_rdata)
    );
endmodule

// File: rtl/async_sram_ctrl_chk.sv
`timescale 1ns/1ps
// Pin-level protocol checker for async_sram_ctrl, attached by bind.
// Recomputes the phase lengths from the same time parameters.
module async_sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int T_RC_PS       = 35000,
    parameter int T_OE_PS       = 15000,
    parameter int T_OE_HZ_PS    = 12000,
    parameter int MIN_TURN      = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic              req_ack
);
    localparam int RD_CYC   = imax(cyc_ceil(T_RC_PS, CLK_PERIOD_PS),
                                   cyc_ceil(T_OE_PS, CLK_PERIOD_PS));
    localparam int TURN_CYC = imax(MIN_TURN,
                                   cyc_ceil(T_OE_HZ_PS, CLK_PERIOD_PS));

    logic [7:0] oe_run_q, gap_q;

    // Length of the current run of output-enable cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)         oe_run_q <= '0;
        else if (!mem_oe_n) oe_run_q <= oe_run_q + 1'b1;
        else                oe_run_q <= '0;
    end

    // Released cycles since the last output-enable cycle, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               gap_q <= 8'hFF;
        else if (!mem_oe_n)       gap_q <= '0;
        else if (gap_q != 8'hFF)  gap_q <= gap_q + 1'b1;
    end

    // R5
    no_drive_during_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R9
    no_strobe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));

    // R2
    strobe_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n) |-> (!mem_ce_n && mem_ce));

    // R4
    data_during_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R4
    addr_steady_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    // R3
    read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_run_q == 8'(RD_CYC)));

    // R7
    read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> req_ack);

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (gap_q >= 8'(TURN_CYC)));

    // R8
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe && !req_ack));
endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .T_RC_PS       (T_RC_PS),
    .T_OE_PS       (T_OE_PS),
    .T_OE_HZ_PS    (T_OE_HZ_PS),
    .MIN_TURN      (MIN_TURN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .req_ack   (req_ack)
);

// File: tb/async_sram_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: small 64-byte memory model, full address sweeps, mixed
// read/write traffic and standby scenarios at a 5 ns clock.
module async_sram_ctrl_bench;
    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int CLK = 5000;
    // Expected phase lengths worked out from the times below.
    localparam int RD_E   = ((35000 + CLK - 1) / CLK > (15000 + CLK - 1) / CLK)
                          ? (35000 + CLK - 1) / CLK : (15000 + CLK - 1) / CLK;
    localparam int STRB_E = ((20000 + CLK - 1) / CLK > (15000 + CLK - 1) / CLK)
                          ? (20000 + CLK - 1) / CLK : (15000 + CLK - 1) / CLK;
    localparam int TURN_E = ((12000 + CLK - 1) / CLK > 2) ? (12000 + CLK - 1) / CLK : 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, standby_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ack, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;

    int errors = 0, checks = 0, acks = 0, reqs = 0, cycles = 0;
    logic mon_on = 1'b0;
    logic [DW-1:0] model [64];
    logic [DW-1:0] expv  [64];

    always #2.5 clk = ~clk;

    async_sram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_PS(CLK)
    ) u_async_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
        .rsp_rdata(rsp_rdata), .standby_req(standby_req), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // Memory model: drives when selected with output enable low.
    assign mem_dq_in = (!mem_ce_n && mem_ce && mem_we_n && !mem_oe_n)
                     ? model[mem_addr] : 'z;
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n && mem_ce && mem_dq_oe) model[mem_addr] <= mem_dq_out;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pin monitor sampled at the falling edge.
    int   oe_run = 0, we_run = 0, gap = 100;
    logic p_we_n = 1, p_dq_oe = 0, p_ack = 0;
    logic [AW-1:0] p_addr = '0;
    always @(negedge clk) begin
        if (mon_on) begin
            if (req_ack) acks++;
            chk(!(mem_dq_oe && !mem_oe_n), "R5", "drive with oe low", mem_dq_oe, 0);
            chk(!(!mem_we_n && !mem_oe_n), "R9", "we and oe both low", 1, 0);
            if (!mem_we_n || !mem_oe_n)
                chk(!mem_ce_n && mem_ce, "R2", "strobe while deselected", mem_ce_n, 0);
            if (!mem_oe_n) begin
                oe_run++;
            end else if (oe_run > 0) begin
                chk(oe_run == RD_E, "R3", "oe low length", oe_run, RD_E);
                chk(req_ack == 1'b1, "R7", "read ack after oe rise", req_ack, 1);
                oe_run = 0;
            end
            if (!mem_we_n) begin
                chk(mem_dq_oe, "R4", "data during strobe", mem_dq_oe, 1);
                if (we_run == 0) chk(p_dq_oe, "R4", "data before strobe", p_dq_oe, 1);
                else chk(mem_addr == p_addr, "R4", "addr steady", mem_addr, p_addr);
                we_run++;
            end else if (we_run > 0) begin
                chk(we_run == STRB_E, "R4", "strobe length", we_run, STRB_E);
                chk(mem_dq_oe, "R4", "data hold after strobe", mem_dq_oe, 1);
                chk(req_ack == 1'b1, "R7", "write ack after we rise", req_ack, 1);
                we_run = 0;
            end
            if (mem_dq_oe && !p_dq_oe)
                chk(gap >= TURN_E, "R6", "turnaround gap", gap, TURN_E);
            if (req_ack && p_ack) chk(0, "R7", "ack longer than one cycle", 2, 1);
            gap = !mem_oe_n ? 0 : gap + 1;
            p_we_n = mem_we_n; p_dq_oe = mem_dq_oe; p_ack = req_ack; p_addr = mem_addr;
        end
    end

    // One access; waits for the acknowledge and checks read data.
    task automatic access(input bit wr, input int a, input logic [DW-1:0] d);
        int n = 0;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d; reqs++;
        do begin
            @(negedge clk); n++;
        end while (!req_ack && n < 200);
        chk(req_ack, wr ? "R4" : "R3", "ack seen", req_ack, 1);
        if (!wr) chk(rsp_rdata == expv[a], "R3", "read data", rsp_rdata, expv[a]);
        else expv[a] = d;
        req_valid = 0;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin model[i] = '0; expv[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!mem_ce_n && mem_ce, "R1", "reset enables", {mem_ce_n, mem_ce}, 1);
        chk(mem_we_n && mem_oe_n, "R1", "reset strobes", {mem_we_n, mem_oe_n}, 3);
        chk(!mem_dq_oe && !req_ack, "R1", "reset drive/ack", {mem_dq_oe, req_ack}, 0);
        rst_n = 1; mon_on = 1;
        // Sweep: write every address, then read every address.
        for (int a = 0; a < 64; a++) access(1, a, DW'(a * 29 + 7));
        for (int a = 0; a < 64; a++) access(0, a, '0);
        // Alternating read then write to the neighbour (turnaround, R6).
        for (int a = 0; a < 64; a++) begin
            access(0, a, '0);
            access(1, a ^ 1, DW'(~(a * 3)));
        end
        for (int a = 63; a >= 0; a--) access(0, a, '0);
        // R8: standby from idle, pending request held off.
        @(negedge clk); standby_req = 1;
        @(negedge clk);
        chk(mem_ce_n && !mem_ce, "R8", "standby deselect", {mem_ce_n, mem_ce}, 2);
        req_valid = 1; req_write = 0; req_addr = 6'd5; reqs++;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(!req_ack && mem_oe_n && mem_ce_n, "R8", "held off in standby",
                {req_ack, mem_oe_n, mem_ce_n}, 3);
        end
        standby_req = 0;
        begin
            int n = 0;
            do begin @(negedge clk); n++; end while (!req_ack && n < 200);
            chk(rsp_rdata == expv[5], "R8", "read after standby", rsp_rdata, expv[5]);
        end
        req_valid = 0;
        // R8: standby and request arrive together; standby wins.
        @(negedge clk); standby_req = 1; req_valid = 1; req_write = 1;
        req_addr = 6'd9; req_wdata = 8'hA5; reqs++;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n, "R8", "standby priority", {mem_ce_n, mem_we_n}, 3);
        standby_req = 0;
        begin
            int n = 0;
            do begin @(negedge clk); n++; end while (!req_ack && n < 200);
        end
        req_valid = 0; expv[9] = 8'hA5;
        access(0, 9, '0);
        // R8: standby raised mid-read takes effect after the read completes.
        @(negedge clk); req_valid = 1; req_write = 0; req_addr = 6'd20; reqs++;
        @(negedge clk); standby_req = 1;
        begin
            int n = 0;
            do begin @(negedge clk); n++; end while (!req_ack && n < 200);
            chk(rsp_rdata == expv[20], "R8", "read finishes first", rsp_rdata, expv[20]);
        end
        req_valid = 0;
        @(negedge clk); @(negedge clk);
        chk(mem_ce_n && !mem_ce, "R8", "standby after read", {mem_ce_n, mem_ce}, 2);
        standby_req = 0;
        repeat (4) @(negedge clk);
        // R9: one acknowledge per request.
        chk(acks == reqs, "R9", "ack count", acks, reqs);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule